// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Timing Selector

This block tells a DRAM command timer which core timing values to enforce: row-to-column delay (tRCD), row active time (tRAS), write recovery (tWR) and precharge time (tRP). It holds a small number of timing profiles. Each profile is given in picoseconds and is safe up to its own temperature limit. The fastest profile covers the coolest range. The slowest profile covers the highest supported temperature, 85 °C. Against the worst-case profile, the coolest one shortens tRCD by roughly 17%, tRP by roughly 35%, tRAS by roughly 37% and tWR by roughly 54%.

On every clock the block compares a temperature reading with the profile limits. When the chosen profile is slower than the one in use, it switches at once. A move to a faster profile waits until no bank reports an open timing window. A hysteresis margin stops the choice from flickering near a limit. If the reading is flagged invalid, the block falls back to the worst-case profile. Profile values are converted to clock cycles at elaboration, rounding up.

Top module: `dram_tmg_sel`

## Requirements
- R1: While reset is asserted and after its release, the active profile is the worst-case one: set_idx = 2, and the outputs are t_rcd = 11, t_ras = 28, t_wr = 12, t_rp = 11.
- R2: The outputs are the active profile's picosecond values divided by the 1250 ps clock period and rounded up. The default cycle counts are as follows. Profile 0 gives rcd/ras/wr/rp = 10/18/6/8. Profile 1 gives 10/23/8/9. Profile 2 gives 11/28/12/11.
- R3: set_idx numbers the profiles 0 (fastest) to 2 (slowest). Their upper limits are 45, 65 and 85 °C, and each limit is inclusive. The target profile is the lowest-numbered one whose limit is at or above the reading.
- R4: A valid reading above 85 °C selects profile 2.
- R5: When temp_valid is 0, the next clock edge makes profile 2 active, whatever the reading or bank_busy.
- R6: A target slower than the active profile becomes active at the next clock edge, even when bank_busy is nonzero.
- R7: A move to a faster profile does not happen while any bank_busy bit is 1. It happens at the first clock edge at which bank_busy is all zeros.
- R8: A move to a faster profile needs the reading plus 2 °C to be at or below that profile's limit. For example, from profile 1, a reading of 44 keeps profile 1 and a reading of 43 selects profile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | 1 when temp_c holds a trusted reading |
| temp_c | input | 8 | Temperature in whole °C, unsigned |
| bank_busy | input | 8 | One bit per bank; 1 while that bank has a timing window running |
| set_idx | output | 2 | Active profile number |
| t_rcd | output | 6 | Row-to-column delay in cycles |
| t_ras | output | 6 | Row active time in cycles |
| t_wr | output | 6 | Write recovery time in cycles |
| t_rp | output | 6 | Precharge time in cycles |

## Verification
A new reading or busy pattern takes effect one clock edge later, because the profile register is the only register between the inputs and the outputs. set_idx and the four timing outputs then change together, combinationally from that register. The driver applies each stimulus on a falling edge and queues the expected profile for the next rising edge. The monitor compares the outputs 5 ns after that rising edge, so every check lands in the first cycle the result is due. Held-off faster moves are checked in the same way, for each cycle the busy mask stays set.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;

  typedef enum logic [1:0] {
    MV_HOLD   = 2'd0,
    MV_SLOWER = 2'd1,
    MV_FASTER = 2'd2
  } move_e;

  // Round a picosecond figure up to whole clock cycles.
  function automatic int unsigned ps_to_cyc(input int unsigned ps, input int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/tsel_classify.sv
`timescale 1ns/1ps
module tsel_classify
  import tsel_pkg::*;
#(
  parameter int NSETS  = 3,
  parameter int TEMP_W = 8,
  parameter int HYST   = 2,
  parameter int IDX_W  = 2,
  parameter logic [NSETS*TEMP_W-1:0] LIMITS = '0
) (
  input  logic              temp_valid_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [IDX_W-1:0]  cur_i,
  output logic [IDX_W-1:0]  nxt_o,
  output move_e             move_o
);

  localparam logic [IDX_W-1:0] WORST = IDX_W'(NSETS - 1);

  logic [IDX_W-1:0]  up_idx;
  logic [IDX_W-1:0]  dn_idx;
  logic [TEMP_W:0]   temp_ext;
  logic [TEMP_W:0]   temp_hyst;

  assign temp_ext  = {1'b0, temp_i};
  assign temp_hyst = temp_ext + (TEMP_W+1)'(HYST);

  // Lowest set whose limit covers the reading (up) and the reading plus margin (dn).
  always_comb begin
    up_idx = WORST;
    dn_idx = WORST;
    for (int i = NSETS - 1; i >= 0; i--) begin
      if (temp_ext  <= {1'b0, LIMITS[i*TEMP_W +: TEMP_W]}) up_idx = IDX_W'(i);
      if (temp_hyst <= {1'b0, LIMITS[i*TEMP_W +: TEMP_W]}) dn_idx = IDX_W'(i);
    end
    if (!temp_valid_i) begin
      up_idx = WORST;
      dn_idx = WORST;
    end
  end

  always_comb begin
    move_o = MV_HOLD;
    nxt_o  = cur_i;
    if (up_idx > cur_i) begin
      move_o = MV_SLOWER;
      nxt_o  = up_idx;
    end else if (dn_idx < cur_i) begin
      move_o = MV_FASTER;
      nxt_o  = dn_idx;
    end
  end

endmodule

// File: rtl/tsel_ctrl.sv
`timescale 1ns/1ps
module tsel_ctrl
  import tsel_pkg::*;
#(
  parameter int NSETS = 3,
  parameter int NBANK = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            move_i,
  input  logic [IDX_W-1:0] nxt_i,
  input  logic [NBANK-1:0] busy_i,
  output logic [IDX_W-1:0] cur_o
);

  localparam logic [IDX_W-1:0] WORST = IDX_W'(NSETS - 1);

  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] cur_d;
  logic             cur_en;
  logic             all_idle;

  assign all_idle = (busy_i == '0);

  always_comb begin
    cur_d = cur_q;
    unique case (move_i)
      MV_SLOWER: cur_d = nxt_i;
      MV_FASTER: if (all_idle) cur_d = nxt_i;
      default:   cur_d = cur_q;
    endcase
    cur_en = (cur_d != cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= WORST;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  assign cur_o = cur_q;

  AST_SLOWER_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (move_i == MV_SLOWER) |=> (cur_q == $past(nxt_i))); // R6

  AST_FASTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q < $past(cur_q)) |-> ($past(busy_i) == '0)); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((move_i == MV_FASTER) && (busy_i != '0)) |=> $stable(cur_q)); // R7

endmodule

// File: rtl/tsel_rom.sv
`timescale 1ns/1ps
module tsel_rom
  import tsel_pkg::*;
#(
  parameter int NSETS  = 3,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 6,
  parameter int CLK_PS = 1250,
  parameter logic [NSETS*32-1:0] RCD_PS = '0,
  parameter logic [NSETS*32-1:0] RAS_PS = '0,
  parameter logic [NSETS*32-1:0] WR_PS  = '0,
  parameter logic [NSETS*32-1:0] RP_PS  = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] rcd_o,
  output logic [CNT_W-1:0] ras_o,
  output logic [CNT_W-1:0] wr_o,
  output logic [CNT_W-1:0] rp_o
);

  logic [CNT_W-1:0] rcd_tab [NSETS];
  logic [CNT_W-1:0] ras_tab [NSETS];
  logic [CNT_W-1:0] wr_tab  [NSETS];
  logic [CNT_W-1:0] rp_tab  [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    localparam int unsigned RCD_C = ps_to_cyc(RCD_PS[g*32 +: 32], CLK_PS);
    localparam int unsigned RAS_C = ps_to_cyc(RAS_PS[g*32 +: 32], CLK_PS);
    localparam int unsigned WR_C  = ps_to_cyc(WR_PS[g*32 +: 32],  CLK_PS);
    localparam int unsigned RP_C  = ps_to_cyc(RP_PS[g*32 +: 32],  CLK_PS);
    assign rcd_tab[g] = CNT_W'(RCD_C);
    assign ras_tab[g] = CNT_W'(RAS_C);
    assign wr_tab[g]  = CNT_W'(WR_C);
    assign rp_tab[g]  = CNT_W'(RP_C);
  end

  always_comb begin
    rcd_o = rcd_tab[NSETS-1];
    ras_o = ras_tab[NSETS-1];
    wr_o  = wr_tab[NSETS-1];
    rp_o  = rp_tab[NSETS-1];
    for (int i = 0; i < NSETS; i++) begin
      if (idx_i == IDX_W'(i)) begin
        rcd_o = rcd_tab[i];
        ras_o = ras_tab[i];
        wr_o  = wr_tab[i];
        rp_o  = rp_tab[i];
      end
    end
  end

endmodule

// File: rtl/dram_tmg_sel.sv
`timescale 1ns/1ps
module dram_tmg_sel
  import tsel_pkg::*;
#(
  parameter int NSETS  = 3,
  parameter int NBANK  = 8,
  parameter int TEMP_W = 8,
  parameter int CNT_W  = 6,
  parameter int HYST   = 2,
  parameter int CLK_PS = 1250,
  parameter logic [NSETS*TEMP_W-1:0] LIMITS = {8'd85, 8'd65, 8'd45},
  parameter logic [NSETS*32-1:0] RCD_PS = {32'd13750, 32'd12500, 32'd11400},
  parameter logic [NSETS*32-1:0] RAS_PS = {32'd35000, 32'd28000, 32'd22050},
  parameter logic [NSETS*32-1:0] WR_PS  = {32'd15000, 32'd10000, 32'd6900},
  parameter logic [NSETS*32-1:0] RP_PS  = {32'd13750, 32'd11250, 32'd8940},
  localparam int IDX_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [NBANK-1:0]  bank_busy,
  output logic [IDX_W-1:0]  set_idx,
  output logic [CNT_W-1:0]  t_rcd,
  output logic [CNT_W-1:0]  t_ras,
  output logic [CNT_W-1:0]  t_wr,
  output logic [CNT_W-1:0]  t_rp
);

  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] nxt_idx;
  move_e            move;

  tsel_classify #(
    .NSETS(NSETS), .TEMP_W(TEMP_W), .HYST(HYST), .IDX_W(IDX_W), .LIMITS(LIMITS)
  ) u_classify (
    .temp_valid_i(temp_valid),
    .temp_i      (temp_c),
    .cur_i       (cur_idx),
    .nxt_o       (nxt_idx),
    .move_o      (move)
  );

  tsel_ctrl #(
    .NSETS(NSETS), .NBANK(NBANK), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .move_i(move),
    .nxt_i (nxt_idx),
    .busy_i(bank_busy),
    .cur_o (cur_idx)
  );

  tsel_rom #(
    .NSETS(NSETS), .IDX_W(IDX_W), .CNT_W(CNT_W), .CLK_PS(CLK_PS),
    .RCD_PS(RCD_PS), .RAS_PS(RAS_PS), .WR_PS(WR_PS), .RP_PS(RP_PS)
  ) u_rom (
    .idx_i(cur_idx),
    .rcd_o(t_rcd),
    .ras_o(t_ras),
    .wr_o (t_wr),
    .rp_o (t_rp)
  );

  assign set_idx = cur_idx;

  AST_INVALID_WORST: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_valid |=> (set_idx == IDX_W'(NSETS - 1))); // R5

  AST_FASTER_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (set_idx < $past(set_idx)) |-> $past(temp_valid)); // R8

endmodule

// File: tb/dram_tmg_sel_bench.sv
`timescale 1ns/1ps
module dram_tmg_sel_bench;

  typedef struct {
    int    set;
    string tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       temp_valid;
  logic [7:0] temp_c;
  logic [7:0] bank_busy;
  logic [1:0] set_idx;
  logic [5:0] t_rcd, t_ras, t_wr, t_rp;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t exp_q[$];

  dram_tmg_sel u_dram_tmg_sel (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_c(temp_c),
    .bank_busy(bank_busy), .set_idx(set_idx),
    .t_rcd(t_rcd), .t_ras(t_ras), .t_wr(t_wr), .t_rp(t_rp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Cycle counts per profile, from R2.
  function automatic int want_rcd(input int s); return (s == 0) ? 10 : (s == 1) ? 10 : 11; endfunction
  function automatic int want_ras(input int s); return (s == 0) ? 18 : (s == 1) ? 23 : 28; endfunction
  function automatic int want_wr (input int s); return (s == 0) ?  6 : (s == 1) ?  8 : 12; endfunction
  function automatic int want_rp (input int s); return (s == 0) ?  8 : (s == 1) ?  9 : 11; endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (int'(set_idx) != e.set || int'(t_rcd) != want_rcd(e.set) || int'(t_ras) != want_ras(e.set) ||
        int'(t_wr) != want_wr(e.set) || int'(t_rp) != want_rp(e.set)) begin
      errors++;
      $display("FAIL %s: got set=%0d rcd=%0d ras=%0d wr=%0d rp=%0d, expected set=%0d rcd=%0d ras=%0d wr=%0d rp=%0d",
               e.tag, set_idx, t_rcd, t_ras, t_wr, t_rp,
               e.set, want_rcd(e.set), want_ras(e.set), want_wr(e.set), want_rp(e.set));
    end
  endtask

  // Driver: apply inputs on the falling edge, queue the profile due after the next rising edge.
  task automatic step(input bit v, input int t, input logic [7:0] busy, input int set, input string tag);
    exp_t e;
    @(negedge clk);
    temp_valid = v;
    temp_c     = 8'(t);
    bank_busy  = busy;
    e.set = set;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; temp_valid = 1'b1; temp_c = 8'd20; bank_busy = 8'h00;
    repeat (3) @(posedge clk);
    #5;
    r.set = 2; r.tag = "R1 during reset";
    compare(r);
    @(negedge clk);
    rst_n = 1'b1;
    temp_valid = 1'b0;
    // R1: stays worst just after release.
    step(1'b0, 20, 8'h00, 2, "R1 after release");
    step(1'b1, 30, 8'h00, 0, "R3 cool reading selects fastest");
    step(1'b1, 50, 8'h00, 1, "R6 warmer reading, slower now");
    step(1'b1, 70, 8'hFF, 2, "R6 slower while busy");
    step(1'b1, 90, 8'h00, 2, "R4 reading above top limit");
    step(1'b1, 60, 8'h01, 2, "R7 faster held, bank 0 busy");
    step(1'b1, 60, 8'h80, 2, "R7 faster held, bank 7 busy");
    step(1'b1, 60, 8'h00, 1, "R7 faster on idle edge");
    step(1'b1, 64, 8'h00, 1, "R8 inside margin keeps set");
    step(1'b1, 44, 8'h00, 1, "R8 44 keeps set 1");
    step(1'b1, 43, 8'h00, 0, "R8 43 moves to set 0");
    step(1'b1, 45, 8'h00, 0, "R3 limit 45 inclusive");
    step(1'b1, 46, 8'h00, 1, "R3 46 leaves set 0");
    step(1'b1, 65, 8'h00, 1, "R3 limit 65 inclusive");
    step(1'b1, 66, 8'h00, 2, "R3 66 leaves set 1");
    step(1'b1, 85, 8'h00, 2, "R4 85 stays worst");
    step(1'b1, 10, 8'h00, 0, "R2 fastest cycle counts");
    step(1'b0, 10, 8'h3C, 2, "R5 invalid forces worst while busy");
    step(1'b0, 10, 8'h00, 2, "R5 invalid holds worst");
    step(1'b1, 10, 8'h00, 0, "R5 valid again returns to fastest");
    step(1'b1, 255, 8'h00, 2, "R4 maximum reading");
    step(1'b1, 50, 8'h00, 1, "R2 middle cycle counts");
    @(negedge clk);
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule